// File: doc/BRIEF.md
# Multiplexed Address/Data Host Port

This block is the host side of an external parallel port. It drives one 16-pin bus that carries address and data at different times, and marks the address phase with an address-latch strobe. Two transfer widths are available. In byte mode a 24-bit address is sent in two parts: the upper two bytes go out while the latch strobe is high, and the low byte shares the following phase with 8 bits of data. In halfword mode the strobe phase carries a 16-bit address and the next phase carries 16 bits of data. Reads release the data lanes so that the external device can drive them, and the value is captured on the last cycle of the strobe.

The core starts a transfer with a one-cycle request pulse while `ready` is high. It gets a one-cycle `ack` when the data phase ends, and `rdata` for a read. The lengths of the address and data phases are set per transfer. A port-off control turns the whole bus into 16 general-purpose flag pins. In that state each group of four flags has its own enable, and a request is refused with `err` and makes no bus activity.

The pad side uses separate output, output-enable and input vectors, so the block itself contains no tristate logic.

Top module: `mux_ad_port`

## Requirements
- R1: During and after reset, `ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ack`=0, `err`=0 and `ad_oe`=16'h0000.
- R2: A request accepted with `addr_len`=A and `data_len`=D gives `ale` high for A+1 cycles. After that, `rd_n` (read) or `wr_n` (write) is low for D+1 cycles. Then one hold cycle has `ack`=1 and both strobes high, and `ready` returns on the cycle after that.
- R3: In byte mode (`req_wide`=0), during the address phase `ad_o[15:8]`=A[23:16], `ad_o[7:0]`=A[15:8], and `ad_oe`=16'hFFFF.
- R4: In byte mode, during the data phase `ad_o[15:8]`=A[7:0] with those pins enabled. For a write, `ad_o[7:0]`=D[7:0] and `ad_oe`=16'hFFFF. For a read, `ad_oe`=16'hFF00.
- R5: In halfword mode (`req_wide`=1), during the address phase `ad_o`=A[15:0] and `ad_oe`=16'hFFFF.
- R6: In halfword mode, during the data phase a write drives `ad_o`=D[15:0] with `ad_oe`=16'hFFFF, and a read gives `ad_oe`=16'h0000.
- R7: A read samples `ad_i` on the last data-phase cycle. `rdata` is `ad_i` in halfword mode and {8'h00, `ad_i[7:0]`} in byte mode. It is valid from the hold cycle and does not change until the next read.
- R8: While `port_off`=1, a request taken with `ready`=1 gives `err`=1 on the next cycle for one cycle. It raises no `ale`, `rd_n` or `wr_n` activity and leaves `ready` high.
- R9: In flag mode, the pin/flag mapping swaps the two halves of the bus. Pin p corresponds to flag p XOR 8, so pins 0..7 are flags 8..15 and pins 8..15 are flags 0..7. The pin drives `flag_dout[f]`, and `flag_din[f]` reads pin p.
- R10: While idle with `port_off`=1, a pin is enabled only when `flag_dir[f]`=1 and group enable `flag_grp_en[f/4]`=1, where f is the pin's flag number.
- R11: A request that arrives while `ready`=0 is ignored. It does not change the current transfer and does not start another one.
- R12: While idle with `port_off`=0, `ad_oe`=16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_off | input | 1 | 1 turns the bus into flag pins and refuses requests |
| flag_grp_en | input | 4 | Enable per group of four flags |
| flag_dir | input | 16 | Per-flag direction, 1 = output |
| flag_dout | input | 16 | Flag output values |
| flag_din | output | 16 | Flag input values read from the pins |
| req | input | 1 | One-cycle transfer request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = halfword mode, 0 = byte mode |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data |
| addr_len | input | 4 | Address-phase length minus one |
| data_len | input | 4 | Data-phase length minus one |
| ready | output | 1 | Idle and able to accept a request |
| ack | output | 1 | One-cycle pulse in the hold cycle |
| err | output | 1 | One-cycle refusal pulse |
| rdata | output | 16 | Last read result |
| ad_o | output | 16 | Bus pin output values |
| ad_oe | output | 16 | Bus pin output enables |
| ad_i | input | 16 | Bus pin input values |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume a clean synchronous reset. They also assume that any `req` seen while busy is dropped by the block rather than queued, so no strobe can start outside the acceptance from idle. The stimulus changes every input only on falling clock edges. `req` is a single-cycle pulse, raised once deliberately while busy to exercise R11. `ad_i` changes during a read's data phase, so a capture on the wrong cycle would give a different `rdata`.

// File: rtl/mux_ad_pkg.sv
package mux_ad_pkg;

    localparam int PIN_W  = 16;
    localparam int ADDR_W = 24;
    localparam int HALF_W = PIN_W / 2;
    localparam int GRP_SZ = 4;
    localparam int N_GRP  = PIN_W / GRP_SZ;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef struct packed {
        logic              wide;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [PIN_W-1:0]  wdata;
    } xfer_t;

    // Pin word during the strobe (address) phase
    function automatic logic [PIN_W-1:0] addr_word(input xfer_t x);
        if (x.wide) return x.addr[PIN_W-1:0];
        return {x.addr[ADDR_W-1:PIN_W], x.addr[PIN_W-1:HALF_W]};
    endfunction

    // Pin word during the data phase
    function automatic logic [PIN_W-1:0] data_word(input xfer_t x);
        if (x.wide) return x.wdata;
        return {x.addr[HALF_W-1:0], x.wdata[HALF_W-1:0]};
    endfunction

    // Enables during the data phase
    function automatic logic [PIN_W-1:0] data_oe(input xfer_t x);
        if (x.we)   return {PIN_W{1'b1}};
        if (x.wide) return {PIN_W{1'b0}};
        return {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
    endfunction

    // Read result formatting
    function automatic logic [PIN_W-1:0] read_word(input logic wide, input logic [PIN_W-1:0] pins);
        if (wide) return pins;
        return {{HALF_W{1'b0}}, pins[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/mux_ad_seq.sv
module mux_ad_seq
    import mux_ad_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  port_off,
    input  logic                  req,
    input  logic                  req_we,
    input  logic                  req_wide,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [PIN_W-1:0]      req_wdata,
    input  logic [LEN_W-1:0]      addr_len,
    input  logic [LEN_W-1:0]      data_len,
    input  logic [PIN_W-1:0]      ad_i,
    output phase_e                phase,
    output xfer_t                 xfer,
    output logic                  ready,
    output logic                  ack,
    output logic                  err,
    output logic [PIN_W-1:0]      rdata
);

    phase_e            phase_q;
    xfer_t             xfer_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  dlen_q;
    logic              err_q;
    logic [PIN_W-1:0]  rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            xfer_q  <= '0;
            cnt_q   <= '0;
            dlen_q  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            err_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req) begin
                        if (port_off) begin
                            err_q <= 1'b1;
                        end else begin
                            xfer_q.wide  <= req_wide;
                            xfer_q.we    <= req_we;
                            xfer_q.addr  <= req_addr;
                            xfer_q.wdata <= req_wdata;
                            dlen_q       <= data_len;
                            cnt_q        <= addr_len;
                            phase_q      <= PH_ADDR;
                        end
                    end
                end
                PH_ADDR: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= dlen_q;
                        phase_q <= PH_DATA;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_HOLD;
                        if (!xfer_q.we) rdata_q <= read_word(xfer_q.wide, ad_i);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign xfer  = xfer_q;
    assign ready = (phase_q == PH_IDLE);
    assign ack   = (phase_q == PH_HOLD);
    assign err   = err_q;
    assign rdata = rdata_q;

    // R2: hold is entered only from the data phase
    a_r2_hold_after_data: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD) |-> ($past(phase_q) == PH_DATA));

    // R2: acknowledge lasts one cycle
    a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R8: a refusal leaves the sequencer idle
    a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> ready);

    // R11: the transfer descriptor is frozen while busy
    a_r11_xfer_stable: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready)) |-> $stable(xfer_q));

    // R7: read result changes only on entry to hold after a read
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(phase_q == PH_HOLD && !xfer_q.we) |-> $stable(rdata_q));

endmodule

// File: rtl/mux_ad_pinmux.sv
module mux_ad_pinmux
    import mux_ad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  phase_e             phase,
    input  xfer_t              xfer,
    input  logic               port_off,
    input  logic [N_GRP-1:0]   flag_grp_en,
    input  logic [PIN_W-1:0]   flag_dir,
    input  logic [PIN_W-1:0]   flag_dout,
    input  logic [PIN_W-1:0]   ad_i,
    output logic [PIN_W-1:0]   flag_din,
    output logic [PIN_W-1:0]   ad_o,
    output logic [PIN_W-1:0]   ad_oe,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);

    logic [PIN_W-1:0] flag_val;
    logic [PIN_W-1:0] flag_oe;
    logic [PIN_W-1:0] bus_word;
    logic [PIN_W-1:0] bus_oe;
    logic             busy;

    // Flag mapping: pin p carries flag p XOR HALF_W
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        localparam int F = p ^ HALF_W;
        assign flag_val[p] = flag_dout[F];
        assign flag_oe[p]  = port_off & flag_grp_en[F / GRP_SZ] & flag_dir[F];
        assign flag_din[F] = ad_i[p];
    end

    always_comb begin
        bus_word = '0;
        bus_oe   = '0;
        unique case (phase)
            PH_ADDR: begin
                bus_word = addr_word(xfer);
                bus_oe   = {PIN_W{1'b1}};
            end
            PH_DATA: begin
                bus_word = data_word(xfer);
                bus_oe   = data_oe(xfer);
            end
            default: begin
                bus_word = '0;
                bus_oe   = '0;
            end
        endcase
    end

    assign busy  = (phase != PH_IDLE);
    assign ad_o  = busy ? bus_word : flag_val;
    assign ad_oe = busy ? bus_oe   : flag_oe;
    assign ale   = (phase == PH_ADDR);
    assign rd_n  = !((phase == PH_DATA) && !xfer.we);
    assign wr_n  = !((phase == PH_DATA) &&  xfer.we);

    // R6: a halfword read releases every pin while the read strobe is low
    a_r6_wide_read_release: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && xfer.wide) |-> (ad_oe == '0));

    // R4: a byte read never drives the low data lanes
    a_r4_byte_read_low_free: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !xfer.wide) |-> (ad_oe[HALF_W-1:0] == '0));

    // R2: strobes are mutually exclusive
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $countones({ale, !rd_n, !wr_n}) <= 1);

endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port
    import mux_ad_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               port_off,
    input  logic [3:0]         flag_grp_en,
    input  logic [15:0]        flag_dir,
    input  logic [15:0]        flag_dout,
    output logic [15:0]        flag_din,
    input  logic               req,
    input  logic               req_we,
    input  logic               req_wide,
    input  logic [23:0]        req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [LEN_W-1:0]   addr_len,
    input  logic [LEN_W-1:0]   data_len,
    output logic               ready,
    output logic               ack,
    output logic               err,
    output logic [15:0]        rdata,
    output logic [15:0]        ad_o,
    output logic [15:0]        ad_oe,
    input  logic [15:0]        ad_i,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);

    phase_e phase;
    xfer_t  xfer;

    mux_ad_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .port_off  (port_off),
        .req       (req),
        .req_we    (req_we),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .addr_len  (addr_len),
        .data_len  (data_len),
        .ad_i      (ad_i),
        .phase     (phase),
        .xfer      (xfer),
        .ready     (ready),
        .ack       (ack),
        .err       (err),
        .rdata     (rdata)
    );

    mux_ad_pinmux u_pinmux (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .xfer        (xfer),
        .port_off    (port_off),
        .flag_grp_en (flag_grp_en),
        .flag_dir    (flag_dir),
        .flag_dout   (flag_dout),
        .ad_i        (ad_i),
        .flag_din    (flag_din),
        .ad_o        (ad_o),
        .ad_oe       (ad_oe),
        .ale         (ale),
        .rd_n        (rd_n),
        .wr_n        (wr_n)
    );

    // R8: a refused request has no strobe activity
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!ale && rd_n && wr_n));

    // R2: the latch strobe only starts from idle
    a_r2_ale_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> $past(ready));

    // R12: idle with the port on leaves the bus released
    a_r12_idle_release: assert property (@(posedge clk) disable iff (rst)
        (ready && !port_off) |-> (ad_oe == 16'h0000));

endmodule

// File: tb/mux_ad_port_bench.sv
`timescale 1ns/1ps
module mux_ad_port_bench;

    typedef struct packed {
        logic        wide;
        logic        we;
        logic [23:0] addr;
        logic [15:0] data;
        logic [3:0]  alen;
        logic [3:0]  dlen;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 24'hA1B2C3, 16'h55D4, 4'd0, 4'd0},
        '{1'b0, 1'b0, 24'h123456, 16'h9E7F, 4'd1, 4'd2},
        '{1'b1, 1'b1, 24'h00BEEF, 16'hCAFE, 4'd2, 4'd1},
        '{1'b1, 1'b0, 24'h00F00D, 16'h3C5A, 4'd0, 4'd3},
        '{1'b0, 1'b1, 24'hFF0080, 16'h0001, 4'd3, 4'd0},
        '{1'b1, 1'b0, 24'h7E8001, 16'hA5A5, 4'd1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_off = 1'b0;
    logic [3:0]  flag_grp_en = '0;
    logic [15:0] flag_dir = '0;
    logic [15:0] flag_dout = '0;
    logic [15:0] flag_din;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic        req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  addr_len = '0;
    logic [3:0]  data_len = '0;
    logic        ready, ack, err, ale, rd_n, wr_n;
    logic [15:0] rdata, ad_o, ad_oe;
    logic [15:0] ad_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    mux_ad_port u_mux_ad_port (
        .clk(clk), .rst(rst), .port_off(port_off), .flag_grp_en(flag_grp_en),
        .flag_dir(flag_dir), .flag_dout(flag_dout), .flag_din(flag_din),
        .req(req), .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .addr_len(addr_len), .data_len(data_len),
        .ready(ready), .ack(ack), .err(err), .rdata(rdata),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] e_addr(input vec_t v);
        return v.wide ? v.addr[15:0] : {v.addr[23:16], v.addr[15:8]};
    endfunction
    function automatic logic [15:0] e_doe(input vec_t v);
        return v.we ? 16'hFFFF : (v.wide ? 16'h0000 : 16'hFF00);
    endfunction
    function automatic logic [15:0] e_dword(input vec_t v);
        return v.wide ? v.data : {v.addr[7:0], v.data[7:0]};
    endfunction

    // One transfer; inject=1 raises a stray request in the address phase (R11)
    task automatic run_xfer(input vec_t v, input logic inject);
        @(negedge clk);
        req = 1'b1; req_we = v.we; req_wide = v.wide; req_addr = v.addr;
        req_wdata = v.data; addr_len = v.alen; data_len = v.dlen;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i <= int'(v.alen); i++) begin
            chk("R2 ale high", {ale, rd_n, wr_n, ready}, {1'b1, 1'b1, 1'b1, 1'b0});
            chk(v.wide ? "R5 addr pins" : "R3 addr pins", {ad_oe, ad_o}, {16'hFFFF, e_addr(v)});
            if (inject && i == 0) begin
                req = 1'b1; req_addr = ~v.addr; req_wdata = ~v.data; req_we = ~v.we;
            end
            @(negedge clk);
            req = 1'b0; req_addr = v.addr; req_wdata = v.data; req_we = v.we;
        end
        for (int j = 0; j <= int'(v.dlen); j++) begin
            ad_i = (j == int'(v.dlen)) ? v.data : ~v.data;
            chk("R2 data strobe", {ale, rd_n, wr_n}, {1'b0, v.we, ~v.we});
            chk(v.wide ? "R6 data enables" : "R4 data enables", ad_oe, e_doe(v));
            chk(v.wide ? "R6 data pins" : "R4 data pins", ad_o & ad_oe, e_dword(v) & e_doe(v));
            @(negedge clk);
        end
        chk("R2 hold ack", {ack, ale, rd_n, wr_n, ready}, {1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
        if (!v.we) last_rd = v.wide ? v.data : {8'h00, v.data[7:0]};
        chk("R7 rdata", rdata, last_rd);
        @(negedge clk);
        chk("R2 back to ready", {ready, ack}, {1'b1, 1'b0});
        chk("R12 idle released", ad_oe, 16'h0000);
        if (inject) begin
            chk("R11 no second start", ale, 1'b0);
            @(negedge clk);
            chk("R11 still idle", {ale, ready}, {1'b0, 1'b1});
        end
        ad_i = '0;
    endtask

    logic done = 1'b0;

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 reset ctl", {ready, ale, rd_n, wr_n, ack, err}, 6'b101100);
        chk("R1 reset oe", ad_oe, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {ready, ale, rd_n, wr_n, ack, err}, 6'b101100);
        chk("R12 idle released", ad_oe, 16'h0000);

        for (int k = 0; k < NV; k++) run_xfer(VECS[k], 1'b0);

        // R11: stray request during a busy transfer
        run_xfer('{1'b1, 1'b1, 24'h004321, 16'h8421, 4'd2, 4'd1}, 1'b1);

        // R8: refusal while the port is off
        port_off = 1'b1;
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 24'h111111;
        @(negedge clk);
        req = 1'b0;
        chk("R8 err pulse", {err, ale, rd_n, wr_n, ready}, 5'b10111);
        @(negedge clk);
        chk("R8 err single", {err, ale, ready}, 3'b001);

        // R9 / R10: flag mapping and group enables
        flag_grp_en = 4'b1011;
        flag_dir    = 16'hF0FF;
        flag_dout   = 16'hA5C3;
        ad_i        = 16'h1234;
        @(negedge clk);
        begin
            logic [15:0] eo, ev;
            for (int p = 0; p < 16; p++) begin
                int f;
                f = p ^ 8;
                eo[p] = flag_grp_en[f / 4] & flag_dir[f];
                ev[p] = flag_dout[f];
            end
            chk("R10 flag enables", ad_oe, eo);
            chk("R9 flag outputs", ad_o & ad_oe, ev & eo);
        end
        chk("R9 flag inputs", flag_din, 16'h3412);
        flag_grp_en = 4'b1111;
        flag_dir    = 16'hFFFF;
        @(negedge clk);
        chk("R9 flag outputs all", {ad_oe, ad_o}, {16'hFFFF, 16'hC3A5});
        flag_grp_en = 4'b0000;
        @(negedge clk);
        chk("R10 groups off", ad_oe, 16'h0000);

        // R12: port back on, idle released
        port_off = 1'b0;
        @(negedge clk);
        chk("R12 port on idle", ad_oe, 16'h0000);
        chk("R7 rdata kept", rdata, last_rd);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule